// File: doc/BRIEF.md
# Event-Triggered Digital Input Sampler

This block captures a parallel digital input word into a holding register whenever a selected trigger event occurs, then hands the captured word to a process memory as a run of byte writes. Four trigger sources are available. The first is the start of an incoming frame. The second is a rising edge on an external latch pin. The third and fourth are two periodic sync pulses. A three-bit mode input chooses the source. Codes outside the four defined ones switch sampling off.

The input bus and the latch pin are asynchronous, so each passes through a two-flop synchroniser. When a frame starts, `sof_notify` is raised first. Sampling follows `SOF_LEAD` cycles later. This gap lets outside logic refresh the input pins before they are read. A trigger that arrives while the byte writes are still running is held in a single queue slot. Further triggers are dropped until the running sequence ends.

The write sequencer has two states. `ST_IDLE` waits for a trigger. `ST_EMIT` drives one byte write per cycle. Its transitions are:
- START: `ST_IDLE` to `ST_EMIT` on a trigger.
- ADVANCE: `ST_EMIT` to `ST_EMIT`, stepping to the next byte lane.
- CHAIN: from the last lane back to lane 0, taking the queued word or a trigger that arrives in that same cycle.
- FINISH: `ST_EMIT` to `ST_IDLE` after the last lane when nothing is waiting.

Top module: `din_event_sampler`

## Requirements
- R1: `mode_sel` selects the trigger source: 0 is frame start, 1 is the latch pin, 2 is sync pulse 0 and 3 is sync pulse 1. Codes 4 to 7 produce no memory writes, whatever the trigger inputs do.
- R2: In latch mode, every rising edge of `latch_in` causes one capture. The first byte write is visible three clock cycles after `latch_in` rises, because of two synchroniser stages plus edge detection. A falling edge causes nothing.
- R3: In a sync mode, the rising edge of the selected sync input causes a capture, and the first byte write appears in the following cycle. The other sync input has no effect.
- R4: `sof_notify` pulses for one cycle, one cycle after `sof_in` rises, in every mode. In frame-start mode, the capture takes place `SOF_LEAD` (default 4) cycles after the rise. Input data changed in the cycle in which `sof_notify` is seen is the data that gets captured.
- R5: A captured word is written little-endian on consecutive cycles. The address runs from `BASE` (default 0x1000) to `BASE+3`. The byte at `BASE+k` is bits [8k+7:8k].
- R6: After reset, `mem_we` and `sof_notify` are low, and `mem_we` stays low while no sequence runs.
- R7: A trigger that arrives during a running sequence is queued with the data present at that moment. Its four writes follow the running sequence with no idle cycle. A trigger that arrives exactly in the last-lane cycle with the queue empty is chained the same way.
- R8: While the queue slot is full, any further trigger is dropped until the running sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 3 | Trigger source select |
| din | input | DATA_W | Asynchronous input bus |
| latch_in | input | 1 | Asynchronous external latch pin |
| sof_in | input | 1 | Frame-start indication, synchronous |
| sync0_in | input | 1 | Sync pulse 0, synchronous |
| sync1_in | input | 1 | Sync pulse 1, synchronous |
| sof_notify | output | 1 | One-cycle notice issued ahead of a frame-start capture |
| mem_we | output | 1 | Byte write strobe to process memory |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_wdata | output | 8 | Byte write data |

## Verification
The critical coincidence is a new trigger that lands in the same cycle as the final byte write of a sequence. The bench provokes it by timing a sync-0 rising edge to fall in the last-lane cycle, once with the queue empty and once with the queue already full. It judges the empty-queue case by requiring eight back-to-back writes, with the second word equal to the input data at the trigger. It judges the full-queue case by requiring the coincident edge to produce no third word.

// File: rtl/din_pkg.sv
package din_pkg;
    typedef enum logic {ST_IDLE, ST_EMIT} seq_state_t;

    localparam logic [2:0] MODE_FRAME = 3'd0;
    localparam logic [2:0] MODE_LATCH = 3'd1;
    localparam logic [2:0] MODE_SYNC0 = 3'd2;
    localparam logic [2:0] MODE_SYNC1 = 3'd3;
endpackage

// File: rtl/dsmp_sync2.sv
module dsmp_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            sync_o <= '0;
        end else begin
            stage1 <= async_i;
            sync_o <= stage1;
        end
    end
endmodule

// File: rtl/dsmp_trigger.sv
module dsmp_trigger
    import din_pkg::*;
#(
    parameter int SOF_LEAD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       sof_in,
    input  logic       latch_s,
    input  logic       sync0_in,
    input  logic       sync1_in,
    output logic       sof_notify,
    output logic       trig
);
    localparam int CW = $clog2(SOF_LEAD + 1);

    logic          sof_prev, latch_prev, s0_prev, s1_prev;
    logic [CW-1:0] lead_cnt;
    logic          sof_rise, lat_rise, s0_rise, s1_rise, sof_trig;

    assign sof_rise = sof_in & ~sof_prev;
    assign lat_rise = latch_s & ~latch_prev;
    assign s0_rise  = sync0_in & ~s0_prev;
    assign s1_rise  = sync1_in & ~s1_prev;
    assign sof_trig = (lead_cnt == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sof_prev   <= 1'b0;
            latch_prev <= 1'b0;
            s0_prev    <= 1'b0;
            s1_prev    <= 1'b0;
            sof_notify <= 1'b0;
            lead_cnt   <= '0;
        end else begin
            sof_prev   <= sof_in;
            latch_prev <= latch_s;
            s0_prev    <= sync0_in;
            s1_prev    <= sync1_in;
            sof_notify <= sof_rise;
            if (sof_rise)
                lead_cnt <= CW'(SOF_LEAD);
            else if (lead_cnt != '0)
                lead_cnt <= lead_cnt - CW'(1);
        end
    end

    always_comb begin
        unique case (mode_sel)
            MODE_FRAME: trig = sof_trig;
            MODE_LATCH: trig = lat_rise;
            MODE_SYNC0: trig = s0_rise;
            MODE_SYNC1: trig = s1_rise;
            default:    trig = 1'b0;
        endcase
    end

    assert_single_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lat_rise |=> !lat_rise);

    assert_notice_precedes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sof_notify |-> !sof_trig);
endmodule

// File: rtl/dsmp_seq.sv
module dsmp_seq
    import din_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter int          ADDR_W = 16,
    parameter int unsigned BASE   = 32'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [DATA_W-1:0] word_in,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam int LANES = DATA_W / 8;
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int LAST  = LANES - 1;

    seq_state_t        state, state_n;
    logic [LW-1:0]     lane, lane_n;
    logic [DATA_W-1:0] cap, cap_n, pend_word, pend_word_n;
    logic              pend_v, pend_v_n;
    logic              last;
    logic [7:0]        lane_bytes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = cap[g*8 +: 8];
    end

    assign last = (lane == LW'(LAST));

    always_comb begin
        state_n     = state;
        lane_n      = lane;
        cap_n       = cap;
        pend_v_n    = pend_v;
        pend_word_n = pend_word;
        unique case (state)
            ST_IDLE: begin
                if (trig) begin
                    state_n = ST_EMIT;
                    lane_n  = '0;
                    cap_n   = word_in;
                end
            end
            ST_EMIT: begin
                if (!last) begin
                    lane_n = lane + LW'(1);
                    if (trig && !pend_v) begin
                        pend_v_n    = 1'b1;
                        pend_word_n = word_in;
                    end
                end else if (pend_v) begin
                    lane_n   = '0;
                    cap_n    = pend_word;
                    pend_v_n = 1'b0;
                end else if (trig) begin
                    lane_n = '0;
                    cap_n  = word_in;
                end else begin
                    state_n = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lane      <= '0;
            cap       <= '0;
            pend_v    <= 1'b0;
            pend_word <= '0;
        end else begin
            state     <= state_n;
            lane      <= lane_n;
            cap       <= cap_n;
            pend_v    <= pend_v_n;
            pend_word <= pend_word_n;
        end
    end

    always_comb begin
        mem_we    = (state == ST_EMIT);
        mem_addr  = ADDR_W'(BASE) + ADDR_W'(lane);
        mem_wdata = mem_we ? lane_bytes[lane] : 8'h00;
    end

    assert_lane_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT && !last) |=> (state == ST_EMIT && lane == $past(lane) + LW'(1)));

    assert_addr_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= ADDR_W'(BASE) && mem_addr <= ADDR_W'(BASE + LAST)));

    assert_queue_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_v && state == ST_EMIT && !last) |=> (pend_v && $stable(pend_word)));
endmodule

// File: rtl/din_event_sampler.sv
module din_event_sampler #(
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 16,
    parameter int unsigned BASE     = 32'h1000,
    parameter int          SOF_LEAD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic [DATA_W-1:0] din,
    input  logic              latch_in,
    input  logic              sof_in,
    input  logic              sync0_in,
    input  logic              sync1_in,
    output logic              sof_notify,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    logic [DATA_W-1:0] din_s;
    logic              latch_s;
    logic              trig;

    dsmp_sync2 #(.W(DATA_W)) i_din_sync (
        .clk(clk), .rst_n(rst_n), .async_i(din), .sync_o(din_s)
    );

    dsmp_sync2 #(.W(1)) i_latch_sync (
        .clk(clk), .rst_n(rst_n), .async_i(latch_in), .sync_o(latch_s)
    );

    dsmp_trigger #(.SOF_LEAD(SOF_LEAD)) i_trigger (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sof_in(sof_in),
        .latch_s(latch_s), .sync0_in(sync0_in), .sync1_in(sync1_in),
        .sof_notify(sof_notify), .trig(trig)
    );

    dsmp_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(BASE)) i_seq (
        .clk(clk), .rst_n(rst_n), .trig(trig), .word_in(din_s),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    assert_off_codes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel > 3'd3 && !mem_we) |=> !mem_we);
endmodule

// File: tb/test_din_event_sampler.sv
module test_din_event_sampler;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  mode_sel;
    logic [31:0] din;
    logic        latch_in, sof_in, sync0_in, sync1_in;
    logic        sof_notify, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    din_event_sampler i_din_event_sampler (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .din(din),
        .latch_in(latch_in), .sof_in(sof_in), .sync0_in(sync0_in),
        .sync1_in(sync1_in), .sof_notify(sof_notify), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 50000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp<50000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Checks one word's four writes, starting at the current negedge; leaves at the negedge after.
    task automatic expect_word(input logic [31:0] w, input string tag);
        for (int k = 0; k < 4; k++) begin
            check(mem_we == 1'b1, {tag, " R5 we"}, 32'(mem_we), 32'd1);
            check(mem_addr == 16'(16'h1000 + k), {tag, " R5 addr"}, 32'(mem_addr), 32'(16'h1000 + k));
            check(mem_wdata == w[k*8 +: 8], {tag, " R5 byte"}, 32'(mem_wdata), 32'(w[k*8 +: 8]));
            @(negedge clk);
        end
    endtask

    task automatic expect_idle(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            check(mem_we == 1'b0, tag, 32'(mem_we), 32'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 1'b0; mode_sel = 3'd2; din = '0;
        latch_in = 0; sof_in = 0; sync0_in = 0; sync1_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(mem_we == 1'b0, "R6 reset we", 32'(mem_we), 0);
        check(sof_notify == 1'b0, "R6 reset notify", 32'(sof_notify), 0);
        expect_idle(3, "R6 idle after reset");

        // R3: sync-mode sweep, the other sync input ignored
        for (int m = 2; m <= 3; m++) begin
            for (int i = 0; i < 6; i++) begin
                logic [31:0] w;
                w = 32'hA5000000 ^ (32'(i + 1) * 32'h01234567) ^ 32'(m << 12);
                mode_sel = 3'(m); din = w;
                repeat (3) @(negedge clk);
                if (m == 2) sync1_in = 1; else sync0_in = 1;
                @(negedge clk);
                sync0_in = 0; sync1_in = 0;
                expect_idle(3, "R3 other sync ignored");
                if (m == 2) sync0_in = 1; else sync1_in = 1;
                @(negedge clk);
                sync0_in = 0; sync1_in = 0;
                expect_word(w, "R3 sync capture");
                expect_idle(2, "R6 idle after word");
            end
        end

        // R2: latch mode, three-cycle latency, falling edge ignored
        mode_sel = 3'd1;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] w;
            w = 32'h5A5A0000 + 32'(i) * 32'h00110F01;
            din = w;
            repeat (3) @(negedge clk);
            latch_in = 1;
            @(negedge clk);
            expect_idle(2, "R2 latch latency");
            expect_word(w, "R2 latch capture");
            latch_in = 0;
            expect_idle(6, "R2 falling edge ignored");
        end

        // R4: frame-start mode, data refreshed on notice is captured
        mode_sel = 3'd0;
        for (int i = 0; i < 3; i++) begin
            logic [31:0] w2;
            w2 = 32'hC0DE0000 | 32'(i * 16'h1357);
            din = 32'h11111111;
            repeat (3) @(negedge clk);
            sof_in = 1;
            @(negedge clk);
            check(sof_notify == 1'b1, "R4 notify", 32'(sof_notify), 1);
            check(mem_we == 1'b0, "R4 no write at notify", 32'(mem_we), 0);
            din = w2; sof_in = 0;
            @(negedge clk);
            check(sof_notify == 1'b0, "R4 notify one cycle", 32'(sof_notify), 0);
            expect_idle(3, "R4 lead time");
            expect_word(w2, "R4 frame capture");
            expect_idle(2, "R6 idle");
        end

        // R1: disabled codes
        for (int m = 4; m < 8; m++) begin
            mode_sel = 3'(m); din = 32'hDEADBEEF;
            repeat (3) @(negedge clk);
            latch_in = 1; sof_in = 1; sync0_in = 1; sync1_in = 1;
            @(negedge clk);
            latch_in = 0; sof_in = 0; sync0_in = 0; sync1_in = 0;
            expect_idle(8, "R1 disabled code");
        end

        // R7/R8: queued trigger, then a dropped one in the last-lane cycle
        mode_sel = 3'd2; din = 32'h0A0B0C0D;
        repeat (4) @(negedge clk);
        sync0_in = 1; din = 32'h1B2B3B4B;
        fork
            begin
                @(negedge clk); sync0_in = 0;
                @(negedge clk); sync0_in = 1;
                @(negedge clk); sync0_in = 0; din = 32'hFFEE0011;
                @(negedge clk); sync0_in = 1;
                @(negedge clk); sync0_in = 0;
            end
            begin
                @(negedge clk);
                expect_word(32'h0A0B0C0D, "R7 first word");
                expect_word(32'h1B2B3B4B, "R7 queued word");
                expect_idle(5, "R8 extra trigger dropped");
            end
        join

        // R7: trigger in the last-lane cycle with empty queue chains
        din = 32'h76543210;
        repeat (4) @(negedge clk);
        sync0_in = 1;
        fork
            begin
                @(negedge clk); sync0_in = 0; din = 32'h89ABCDEF;
                repeat (3) @(negedge clk);
                sync0_in = 1;
                @(negedge clk); sync0_in = 0;
            end
            begin
                @(negedge clk);
                expect_word(32'h76543210, "R7 running word");
                expect_word(32'h89ABCDEF, "R7 chained word");
                expect_idle(4, "R7 idle after chain");
            end
        join

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule